// File: doc/BRIEF.md
# Parallel Task Grouper

This block takes tasks one at a time, in program order, and gathers consecutive ones into groups that may start at the same moment. Each task names the storage locations it reads and the locations it writes, each as a one-hot-per-location bit mask. A task joins the group being built only when it is fully independent of every task already in that group. Independence means three things. It writes nothing the group reads. It reads nothing the group writes. It writes nothing the group also writes. When any of these overlaps exists, the group being built is closed and handed downstream, and the offending task opens the next group.

Groups also close when they reach a configured size, or when a flush request arrives. Each closed group leaves through a single output register with a valid/ready handshake. That register carries an incrementing group number, the number of tasks in the group, and the union of their read and write masks. Every accepted task is also echoed one cycle later with the group number and slot position it was given. The block never reorders tasks and never executes them.

Top module: `task_grouper`

## Requirements
- R1: After reset `outValid` and `tagValid` are 0, `inReady` is 1, and the first group formed carries group number 0.
- R2: A task that has no overlap with the open group joins it. One cycle after acceptance, `tagValid` is 1, `tagGroup` equals the open group's number, and `tagSlot` equals the number of tasks already in the group (the first task is slot 0).
- R3: A task whose read mask overlaps the open group's accumulated write mask is a conflict. In the accepting cycle the open group closes; one cycle later the output shows it. The task becomes slot 0 of a group whose number is one higher.
- R4: A task whose write mask overlaps the open group's accumulated read mask is a conflict, handled as in R3.
- R5: A task whose write mask overlaps the open group's accumulated write mask is a conflict, handled as in R3.
- R6: A group closes in the cycle its MAX_GROUP-th task (default 4) is accepted, even when the next task would be independent. The output then shows `outCount` = MAX_GROUP.
- R7: Flush behaviour depends on what arrives with it.
  - With no valid task, flush closes a non-empty open group and does nothing to an empty one.
  - With an independent task, the task joins and the group including it closes.
  - With a conflicting task, only the old group closes, and the new group stays open.
- R8: Issued groups carry consecutive group numbers, each one more than the previous modulo 2^ID_W. The issued `outReads`/`outWrites` are the OR of the members' masks.
- R9: While `outValid` is 1 and `outReady` is 0, all output fields hold steady.
- R10: `inReady` is 0 only when the presented task (or flush) would close a group while the output register is full and not being drained. An independent task is accepted even then.
- R11: Two tasks that only read the same location are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Task presented |
| inReady | output | 1 | Task can be taken this cycle |
| inReads | input | 16 | Locations read by the task |
| inWrites | input | 16 | Locations written by the task |
| flush | input | 1 | Close the open group |
| tagValid | output | 1 | A task was accepted in the previous cycle |
| tagGroup | output | 8 | Group number given to that task |
| tagSlot | output | 2 | Position of that task in its group |
| outValid | output | 1 | A closed group is offered |
| outReady | input | 1 | Downstream takes the group |
| outGroupId | output | 8 | Number of the offered group |
| outCount | output | 3 | Tasks in the offered group |
| outReads | output | 16 | Union of members' read masks |
| outWrites | output | 16 | Union of members' write masks |

## Verification
A wrong accumulated mask shows at the next conflicting or independent task. Within one cycle that task's tag is either a fresh slot 0 where it should have joined, or a continued slot where a new group should have begun. The final group mask also appears on `outReads`/`outWrites` when the group is issued. A wrong task count shows as a group that closes one task early or late at the size limit. A wrong group counter shows on the very next tag or issue as a skipped or repeated number. A stuck output register shows as `inReady` falling for a task that needs no issue, or as output fields that change while downstream is stalled.

// File: rtl/grouper_pkg.sv
package grouper_pkg;

  // strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic acceptTask;      // task handshake completes
    logic mergeTask;       // task joins the open group, group stays open
    logic restartWithTask; // task opens a new group after the old one closes
    logic closeOld;        // open group (without the task) goes to output
    logic closeMerged;     // open group plus the task goes to output
  } grpCtlT;

endpackage

// File: rtl/hazard_detect.sv
module hazard_detect #(
  parameter int LOC_W = 16
) (
  input  logic [LOC_W-1:0] taskReads,
  input  logic [LOC_W-1:0] taskWrites,
  input  logic [LOC_W-1:0] grpReads,
  input  logic [LOC_W-1:0] grpWrites,
  output logic             rawHit,
  output logic             warHit,
  output logic             wawHit,
  output logic             conflict
);

  logic [LOC_W-1:0] rawVec;
  logic [LOC_W-1:0] warVec;
  logic [LOC_W-1:0] wawVec;

  // one hazard cell per location
  for (genvar loc = 0; loc < LOC_W; loc++) begin : g_loc
    assign rawVec[loc] = taskReads[loc]  & grpWrites[loc];
    assign warVec[loc] = taskWrites[loc] & grpReads[loc];
    assign wawVec[loc] = taskWrites[loc] & grpWrites[loc];
  end

  assign rawHit   = |rawVec;
  assign warHit   = |warVec;
  assign wawHit   = |wawVec;
  assign conflict = rawHit | warHit | wawHit;

endmodule

// File: rtl/grouper_ctrl.sv
module grouper_ctrl
  import grouper_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   flush,
  input  logic   conflict,
  input  logic   lastSlot,
  input  logic   groupEmpty,
  input  logic   outFree,
  output logic   inReady,
  output grpCtlT ctl
);

  logic wantIssue;
  logic accept;
  logic closeAfterJoin;

  // a presented task forces an issue on conflict, at the size limit or on flush
  assign wantIssue      = conflict | lastSlot | flush;
  assign inReady        = outFree | ~wantIssue;
  assign accept         = inValid & inReady;
  assign closeAfterJoin = lastSlot | flush;

  always_comb begin
    ctl                 = '0;
    ctl.acceptTask      = accept;
    ctl.restartWithTask = accept & conflict;
    ctl.closeOld        = (accept & conflict)
                        | (~inValid & flush & ~groupEmpty & outFree);
    ctl.closeMerged     = accept & ~conflict & closeAfterJoin;
    ctl.mergeTask       = accept & ~conflict & ~closeAfterJoin;
  end

  // R2: at most one group action per cycle
  p_single_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.closeOld, ctl.closeMerged, ctl.mergeTask}));

  // R7: flush alone never closes an empty group
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && groupEmpty) |-> !ctl.closeOld);

endmodule

// File: rtl/grouper_datapath.sv
module grouper_datapath
  import grouper_pkg::*;
#(
  parameter int LOC_W     = 16,
  parameter int MAX_GROUP = 4,
  parameter int ID_W      = 8,
  localparam int CNT_W    = $clog2(MAX_GROUP + 1),
  localparam int SLOT_W   = (MAX_GROUP > 1) ? $clog2(MAX_GROUP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  grpCtlT            ctl,
  input  logic [LOC_W-1:0]  inReads,
  input  logic [LOC_W-1:0]  inWrites,
  input  logic              outReady,
  output logic              conflict,
  output logic              lastSlot,
  output logic              groupEmpty,
  output logic              outFree,
  output logic              tagValid,
  output logic [ID_W-1:0]   tagGroup,
  output logic [SLOT_W-1:0] tagSlot,
  output logic              outValid,
  output logic [ID_W-1:0]   outGroupId,
  output logic [CNT_W-1:0]  outCount,
  output logic [LOC_W-1:0]  outReads,
  output logic [LOC_W-1:0]  outWrites
);

  logic [LOC_W-1:0] grpReads;
  logic [LOC_W-1:0] grpWrites;
  logic [CNT_W-1:0] grpCount;
  logic [ID_W-1:0]  grpId;

  logic [LOC_W-1:0] mergedReads;
  logic [LOC_W-1:0] mergedWrites;
  logic [CNT_W-1:0] mergedCount;
  logic             rawHit;
  logic             warHit;
  logic             wawHit;

  hazard_detect #(.LOC_W(LOC_W)) u_hazard (
    .taskReads (inReads),
    .taskWrites(inWrites),
    .grpReads  (grpReads),
    .grpWrites (grpWrites),
    .rawHit    (rawHit),
    .warHit    (warHit),
    .wawHit    (wawHit),
    .conflict  (conflict)
  );

  assign mergedReads  = grpReads | inReads;
  assign mergedWrites = grpWrites | inWrites;
  assign mergedCount  = grpCount + CNT_W'(1);
  assign groupEmpty   = (grpCount == '0);
  assign outFree      = ~outValid | outReady;

  // size limit: a group of one closes on every task
  if (MAX_GROUP == 1) begin : g_single
    assign lastSlot = 1'b1;
  end else begin : g_multi
    assign lastSlot = (grpCount == CNT_W'(MAX_GROUP - 1));
  end

  // open group accumulation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpReads  <= '0;
      grpWrites <= '0;
      grpCount  <= '0;
      grpId     <= '0;
    end else if (ctl.closeMerged) begin
      grpReads  <= '0;
      grpWrites <= '0;
      grpCount  <= '0;
      grpId     <= grpId + ID_W'(1);
    end else if (ctl.closeOld) begin
      grpId <= grpId + ID_W'(1);
      if (ctl.restartWithTask) begin
        grpReads  <= inReads;
        grpWrites <= inWrites;
        grpCount  <= CNT_W'(1);
      end else begin
        grpReads  <= '0;
        grpWrites <= '0;
        grpCount  <= '0;
      end
    end else if (ctl.mergeTask) begin
      grpReads  <= mergedReads;
      grpWrites <= mergedWrites;
      grpCount  <= mergedCount;
    end
  end

  // issue register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outGroupId <= '0;
      outCount   <= '0;
      outReads   <= '0;
      outWrites  <= '0;
    end else if (ctl.closeMerged) begin
      outValid   <= 1'b1;
      outGroupId <= grpId;
      outCount   <= mergedCount;
      outReads   <= mergedReads;
      outWrites  <= mergedWrites;
    end else if (ctl.closeOld) begin
      outValid   <= 1'b1;
      outGroupId <= grpId;
      outCount   <= grpCount;
      outReads   <= grpReads;
      outWrites  <= grpWrites;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // membership tag of each accepted task
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagValid <= 1'b0;
      tagGroup <= '0;
      tagSlot  <= '0;
    end else begin
      tagValid <= ctl.acceptTask;
      if (ctl.acceptTask) begin
        if (ctl.restartWithTask) begin
          tagGroup <= grpId + ID_W'(1);
          tagSlot  <= '0;
        end else begin
          tagGroup <= grpId;
          tagSlot  <= grpCount[SLOT_W-1:0];
        end
      end
    end
  end

  // R6: the open group never exceeds its limit
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    grpCount <= CNT_W'(MAX_GROUP));

  // R3: a restarted group holds exactly the conflicting task
  p_restart_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restartWithTask |=> (grpCount == CNT_W'(1)) && (grpReads == $past(inReads))
                            && (grpWrites == $past(inWrites)));

  // R9: a stalled offer holds its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outGroupId) && $stable(outCount)
                                && $stable(outReads) && $stable(outWrites));

  // R8: each close advances the group number by one
  p_id_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.closeOld || ctl.closeMerged) |=> grpId == $past(grpId) + ID_W'(1));

  // R7: an issued group is never empty
  p_issue_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.closeOld || ctl.closeMerged) |=> outValid && (outCount != '0));

endmodule

// File: rtl/task_grouper.sv
module task_grouper
  import grouper_pkg::*;
#(
  parameter int LOC_W     = 16,
  parameter int MAX_GROUP = 4,
  parameter int ID_W      = 8,
  localparam int CNT_W    = $clog2(MAX_GROUP + 1),
  localparam int SLOT_W   = (MAX_GROUP > 1) ? $clog2(MAX_GROUP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [LOC_W-1:0]  inReads,
  input  logic [LOC_W-1:0]  inWrites,
  input  logic              flush,
  output logic              tagValid,
  output logic [ID_W-1:0]   tagGroup,
  output logic [SLOT_W-1:0] tagSlot,
  output logic              outValid,
  input  logic              outReady,
  output logic [ID_W-1:0]   outGroupId,
  output logic [CNT_W-1:0]  outCount,
  output logic [LOC_W-1:0]  outReads,
  output logic [LOC_W-1:0]  outWrites
);

  grpCtlT ctl;
  logic   conflict;
  logic   lastSlot;
  logic   groupEmpty;
  logic   outFree;

  grouper_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .flush     (flush),
    .conflict  (conflict),
    .lastSlot  (lastSlot),
    .groupEmpty(groupEmpty),
    .outFree   (outFree),
    .inReady   (inReady),
    .ctl       (ctl)
  );

  grouper_datapath #(
    .LOC_W    (LOC_W),
    .MAX_GROUP(MAX_GROUP),
    .ID_W     (ID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inReads   (inReads),
    .inWrites  (inWrites),
    .outReady  (outReady),
    .conflict  (conflict),
    .lastSlot  (lastSlot),
    .groupEmpty(groupEmpty),
    .outFree   (outFree),
    .tagValid  (tagValid),
    .tagGroup  (tagGroup),
    .tagSlot   (tagSlot),
    .outValid  (outValid),
    .outGroupId(outGroupId),
    .outCount  (outCount),
    .outReads  (outReads),
    .outWrites (outWrites)
  );

  // R10: input stalls only behind a blocked issue register
  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (outValid && !outReady));

endmodule

// File: tb/task_grouper_bench.sv
module task_grouper_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inReads = '0;
  logic [15:0] inWrites = '0;
  logic        flush = 1'b0;
  logic        tagValid;
  logic [7:0]  tagGroup;
  logic [1:0]  tagSlot;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outGroupId;
  logic [2:0]  outCount;
  logic [15:0] outReads;
  logic [15:0] outWrites;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  task_grouper u_task_grouper (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inReads(inReads), .inWrites(inWrites), .flush(flush),
    .tagValid(tagValid), .tagGroup(tagGroup), .tagSlot(tagSlot),
    .outValid(outValid), .outReady(outReady), .outGroupId(outGroupId),
    .outCount(outCount), .outReads(outReads), .outWrites(outWrites)
  );

  typedef struct packed {
    logic [15:0] rd;
    logic [15:0] wr;
    logic        fl;
    logic [7:0]  tGrp;
    logic [1:0]  tSlot;
    logic        iss;
    logic [7:0]  iId;
    logic [2:0]  iCnt;
    logic [15:0] iRd;
    logic [15:0] iWr;
  } vecT;

  // location bits: A=0 B=1 C=2 D=3 E=4 F=5 X=6 W=7
  localparam int NV = 11;
  localparam vecT VEC [NV] = '{
    {16'h0006, 16'h0001, 1'b0, 8'd0, 2'd0, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000}, // R2
    {16'h0032, 16'h0008, 1'b0, 8'd0, 2'd1, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000}, // R11
    {16'h0009, 16'h0040, 1'b0, 8'd1, 2'd0, 1'b1, 8'd0, 3'd2, 16'h0036, 16'h0009}, // R3
    {16'h0022, 16'h0080, 1'b0, 8'd1, 2'd1, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000}, // R2
    {16'h0004, 16'h0020, 1'b0, 8'd2, 2'd0, 1'b1, 8'd1, 3'd2, 16'h002B, 16'h00C0}, // R4
    {16'h0010, 16'h0020, 1'b0, 8'd3, 2'd0, 1'b1, 8'd2, 3'd1, 16'h0004, 16'h0020}, // R5
    {16'h0100, 16'h0200, 1'b0, 8'd3, 2'd1, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000},
    {16'h0400, 16'h0800, 1'b0, 8'd3, 2'd2, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000},
    {16'h1000, 16'h2000, 1'b0, 8'd3, 2'd3, 1'b1, 8'd3, 3'd4, 16'h1510, 16'h2A20}, // R6
    {16'h4000, 16'h8000, 1'b0, 8'd4, 2'd0, 1'b0, 8'd0, 3'd0, 16'h0000, 16'h0000}, // R6
    {16'h0001, 16'h0002, 1'b1, 8'd4, 2'd1, 1'b1, 8'd4, 3'd2, 16'h4001, 16'h8002}  // R7
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic [7:0] id, input logic [2:0] cnt,
                          input logic [15:0] rd, input logic [15:0] wr);
    check(req, "outValid", 32'(outValid), 32'd1);
    check(req, "outGroupId", 32'(outGroupId), 32'(id));
    check(req, "outCount", 32'(outCount), 32'(cnt));
    check(req, "outReads", 32'(outReads), 32'(rd));
    check(req, "outWrites", 32'(outWrites), 32'(wr));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "outValid", 32'(outValid), 32'd0);
    check("R1", "tagValid", 32'(tagValid), 32'd0);
    check("R1", "inReady", 32'(inReady), 32'd1);

    // table walk, one task per cycle, downstream always ready
    for (int i = 0; i < NV; i++) begin
      inValid  = 1'b1;
      inReads  = VEC[i].rd;
      inWrites = VEC[i].wr;
      flush    = VEC[i].fl;
      @(negedge clk);
      check("R2", "tagValid", 32'(tagValid), 32'd1);
      check("R2", "tagGroup", 32'(tagGroup), 32'(VEC[i].tGrp));
      check("R2", "tagSlot", 32'(tagSlot), 32'(VEC[i].tSlot));
      if (VEC[i].iss) checkOut("R8", VEC[i].iId, VEC[i].iCnt, VEC[i].iRd, VEC[i].iWr);
      else check("R3", "outValid idle", 32'(outValid), 32'd0);
    end

    // R7: flush on an empty group issues nothing
    inValid = 1'b0;
    flush   = 1'b1;
    @(negedge clk);
    check("R7", "flush empty outValid", 32'(outValid), 32'd0);
    check("R7", "flush empty tagValid", 32'(tagValid), 32'd0);

    // R7: flush alone closes a partial group (group 5)
    flush    = 1'b0;
    inValid  = 1'b1;
    inReads  = 16'h0001;
    inWrites = 16'h0002;
    @(negedge clk);
    check("R7", "tagGroup", 32'(tagGroup), 32'd5);
    inValid = 1'b0;
    flush   = 1'b1;
    @(negedge clk);
    checkOut("R7", 8'd5, 3'd1, 16'h0001, 16'h0002);
    flush = 1'b0;

    // R9/R10: back-pressure
    outReady = 1'b0;
    @(negedge clk);
    check("R9", "drained", 32'(outValid), 32'd1);
    outReady = 1'b1;
    @(negedge clk);
    check("R9", "empty after drain", 32'(outValid), 32'd0);
    outReady = 1'b0;
    inValid  = 1'b1;
    inReads  = 16'h0001;
    inWrites = 16'h0002;                 // group 6 slot 0
    @(negedge clk);
    check("R2", "tagGroup g6", 32'(tagGroup), 32'd6);
    inReads  = 16'h0002;
    inWrites = 16'h0004;                 // RAW on bit1 -> group 6 issues
    @(negedge clk);
    checkOut("R3", 8'd6, 3'd1, 16'h0001, 16'h0002);
    check("R3", "tagGroup g7", 32'(tagGroup), 32'd7);
    inReads  = 16'h0100;
    inWrites = 16'h0200;                 // independent: ready despite stall
    #1;
    check("R10", "ready independent", 32'(inReady), 32'd1);
    inReads  = 16'h0004;
    inWrites = 16'h0008;                 // RAW on bit2 with a full output
    #1;
    check("R10", "ready conflict blocked", 32'(inReady), 32'd0);
    @(negedge clk);
    check("R9", "held id", 32'(outGroupId), 32'd6);
    check("R9", "held valid", 32'(outValid), 32'd1);
    check("R10", "no accept", 32'(tagValid), 32'd0);
    @(negedge clk);
    check("R9", "held count", 32'(outCount), 32'd1);
    outReady = 1'b1;                     // drain and accept in one cycle
    @(negedge clk);
    checkOut("R10", 8'd7, 3'd1, 16'h0002, 16'h0004);
    check("R10", "tagGroup g8", 32'(tagGroup), 32'd8);
    inValid = 1'b0;
    flush   = 1'b1;
    @(negedge clk);
    checkOut("R7", 8'd8, 3'd1, 16'h0004, 16'h0008);

    // R8: group number wraps modulo 256, one flushed task per group
    inValid  = 1'b1;
    inReads  = 16'h0010;
    inWrites = 16'h0020;
    for (int k = 0; k < 250; k++) begin
      @(negedge clk);
      check("R8", "wrap id", 32'(outGroupId), 32'((9 + k) % 256));
      check("R8", "wrap valid", 32'(outValid), 32'd1);
    end
    inValid = 1'b0;
    flush   = 1'b0;
    @(negedge clk);
    check("R8", "idle after wrap", 32'(outValid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule